// File: doc/BRIEF.md
# Frame Buffer Read Pointer Controller

This block produces the read address for a field or frame buffer memory, running entirely on the read clock except for a small capture stage on the write clock. While the active-low read enable is asserted, the pointer advances by one on every read-clock edge and wraps from the all-ones address back to zero. An active-low clear returns it to zero. An active-low set reloads it from one of three places: the address most recently marked on the write side, a preset value held in a configuration register, or an external address bus.

Clear and set can each be made edge sensitive or level sensitive through their own mode pins. The marked write address crosses into the read domain through a toggle handshake. The read side keeps a stable copy of that address, and set uses the copy. A read strobe to the memory follows the enable one cycle later, which lines it up with the address register. The memory array, the output data path and the rest of the write side are outside this block. No data stream passes through it, so every pin is a plain control or status pin and there is no valid/ready handshake.

Top module: `rdptr_ctrl`

## Requirements
- R1: After reset, rd_addr is 0, rd_strobe is 0 and the held marked address is 0, so a set with mark_sel=0 loads 0 until a mark arrives.
- R2: At each rclk edge where rd_en_n=0 and neither clear nor set is active, rd_addr increments by one.
- R3: At each rclk edge where rd_en_n=1, rd_addr holds its value, even if rd_clr_n or rd_set_n is low.
- R4: With clr_edge_mode=0, every edge where rd_en_n=0 and rd_clr_n=0 sets rd_addr to 0.
- R5: With clr_edge_mode=1, clear acts only at an edge where rd_clr_n is 0 and was 1 at the previous edge. While rd_clr_n stays low after that, the pointer increments. The previous value is sampled at every edge, whatever the state of the enable.
- R6: When set is active, mark_sel=0 loads the held marked address. mark_sel=1 with src_sel=0 loads preset_addr. mark_sel=1 with src_sel=1 loads ext_addr.
- R7: set_edge_mode selects the sensitivity of set. At 0, set acts at every edge while rd_set_n is low. At 1, it acts only at the first edge after a high-to-low change, in the same way as clear in R5.
- R8: If clear and set are active at the same edge, clear wins and rd_addr becomes 0.
- R9: rd_strobe equals the inverse of rd_en_n as sampled at the previous rclk edge.
- R10: A one-cycle wr_mark_stb pulse on wclk captures wr_mark_addr. Within 8 rclk cycles, a set with mark_sel=0 loads that value. This holds as long as pulses are at least 8 rclk cycles apart.
- R11: Incrementing from the all-ones address gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low asynchronous reset, read domain |
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_mark_stb | input | 1 | One-cycle pulse that captures a marked write address |
| wr_mark_addr | input | AW | Write address to mark |
| rd_en_n | input | 1 | Active-low read enable |
| rd_clr_n | input | 1 | Active-low pointer clear |
| rd_set_n | input | 1 | Active-low pointer set |
| clr_edge_mode | input | 1 | 1: clear acts on the falling edge only; 0: level |
| set_edge_mode | input | 1 | 1: set acts on the falling edge only; 0: level |
| mark_sel | input | 1 | 0: set loads the marked address; 1: the source is picked by src_sel |
| src_sel | input | 1 | With mark_sel=1: 0 selects preset_addr, 1 selects ext_addr |
| preset_addr | input | AW | Value of the read-preset configuration register |
| ext_addr | input | AW | External address bus |
| rd_addr | output | AW | Read address to memory |
| rd_strobe | output | 1 | Read strobe, aligned with rd_addr |

## Verification
The assertions take the mode pins to be static while clear or set is in use. They also take the mark strobe to be spaced widely enough that the read side's copy is always settled before the next capture. They check only level-mode clear and set, the idle increment, hold while disabled, and strobe timing. The bench changes a mode pin only while clear and set are released, with a settling edge in between. It issues marks many read cycles apart on a write clock unrelated to the read clock.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;
  typedef enum logic [1:0] {
    SRC_MARK   = 2'd0,
    SRC_PRESET = 2'd1,
    SRC_EXT    = 2'd2
  } set_src_e;

  function automatic set_src_e pick_src(input logic mark_sel, input logic src_sel);
    if (!mark_sel)    return SRC_MARK;
    else if (src_sel) return SRC_EXT;
    else              return SRC_PRESET;
  endfunction
endpackage

// File: rtl/rdptr_mark_sync.sv
module rdptr_mark_sync #(
  parameter int unsigned AW     = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          mark_stb,
  input  logic [AW-1:0] mark_addr,
  input  logic          rclk,
  input  logic          rrst_n,
  output logic [AW-1:0] mark_q
);
  logic [AW-1:0]     hold_w;
  logic              tog_w;
  logic [STAGES-1:0] sync_r;
  logic              seen_r;

  // write domain: capture and flip the request toggle
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      hold_w <= '0;
      tog_w  <= 1'b0;
    end else if (mark_stb) begin
      hold_w <= mark_addr;
      tog_w  <= ~tog_w;
    end
  end

  // read domain: synchronize toggle, then copy the settled hold register
  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      sync_r <= '0;
      seen_r <= 1'b0;
      mark_q <= '0;
    end else begin
      sync_r <= {sync_r[STAGES-2:0], tog_w};
      seen_r <= sync_r[STAGES-1];
      if (sync_r[STAGES-1] != seen_r) mark_q <= hold_w;
    end
  end
endmodule

// File: rtl/rdptr_act_detect.sv
module rdptr_act_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  input  logic edge_mode,
  output logic act
);
  logic prev_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_r <= 1'b1;
    else        prev_r <= sig_n;
  end

  assign act = edge_mode ? (!sig_n && prev_r) : !sig_n;
endmodule

// File: rtl/rdptr_ctrl.sv
module rdptr_ctrl
  import rdptr_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_mark_stb,
  input  logic [AW-1:0] wr_mark_addr,
  input  logic          rd_en_n,
  input  logic          rd_clr_n,
  input  logic          rd_set_n,
  input  logic          clr_edge_mode,
  input  logic          set_edge_mode,
  input  logic          mark_sel,
  input  logic          src_sel,
  input  logic [AW-1:0] preset_addr,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_strobe
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic          clr_act, set_act;
  logic [AW-1:0] mark_q;
  logic [AW-1:0] load_val;
  set_src_e      src;

  rdptr_mark_sync #(.AW(AW), .STAGES(SYNC_STAGES)) u_sync (
    .wclk(wclk), .wrst_n(wrst_n), .mark_stb(wr_mark_stb), .mark_addr(wr_mark_addr),
    .rclk(rclk), .rrst_n(rst_n), .mark_q(mark_q)
  );

  rdptr_act_detect u_clr (
    .clk(rclk), .rst_n(rst_n), .sig_n(rd_clr_n), .edge_mode(clr_edge_mode), .act(clr_act)
  );

  rdptr_act_detect u_set (
    .clk(rclk), .rst_n(rst_n), .sig_n(rd_set_n), .edge_mode(set_edge_mode), .act(set_act)
  );

  always_comb begin
    src = pick_src(mark_sel, src_sel);
    case (src)
      SRC_PRESET: load_val = preset_addr;
      SRC_EXT:    load_val = ext_addr;
      default:    load_val = mark_q;
    endcase
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr   <= '0;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= !rd_en_n;
      if (!rd_en_n) begin
        if (clr_act)      rd_addr <= '0;
        else if (set_act) rd_addr <= load_val;
        else              rd_addr <= rd_addr + STEP;
      end
    end
  end
endmodule

// File: rtl/rdptr_ctrl_chk.sv
module rdptr_ctrl_chk #(
  parameter int unsigned AW = 24
) (
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_en_n,
  input logic          rd_clr_n,
  input logic          rd_set_n,
  input logic          clr_edge_mode,
  input logic          set_edge_mode,
  input logic          mark_sel,
  input logic          src_sel,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] preset_addr,
  input logic [AW-1:0] rd_addr,
  input logic          rd_strobe
);
  a_r9_strobe_follows: assert property (@(posedge rclk) disable iff (!rst_n)
    1'b1 |=> (rd_strobe == !$past(rd_en_n)));

  a_r3_hold_disabled: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_addr));

  a_r2_increment: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en_n && rd_clr_n && rd_set_n) |=> (rd_addr == $past(rd_addr) + AW'(1)));

  a_r4_r8_clear_level: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en_n && !rd_clr_n && !clr_edge_mode) |=> (rd_addr == '0));

  a_r6_set_ext: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en_n && rd_clr_n && !rd_set_n && !set_edge_mode && mark_sel && src_sel)
      |=> (rd_addr == $past(ext_addr)));

  a_r6_set_preset: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en_n && rd_clr_n && !rd_set_n && !set_edge_mode && mark_sel && !src_sel)
      |=> (rd_addr == $past(preset_addr)));
endmodule

bind rdptr_ctrl rdptr_ctrl_chk #(.AW(AW)) u_chk (
  .rclk(rclk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n),
  .rd_set_n(rd_set_n), .clr_edge_mode(clr_edge_mode), .set_edge_mode(set_edge_mode),
  .mark_sel(mark_sel), .src_sel(src_sel), .ext_addr(ext_addr),
  .preset_addr(preset_addr), .rd_addr(rd_addr), .rd_strobe(rd_strobe)
);

// File: tb/rdptr_ctrl_tb.sv
module rdptr_ctrl_tb;
  localparam int AW = 24;

  logic rclk = 1'b0, wclk = 1'b0;
  logic rst_n = 1'b0, wrst_n = 1'b0;
  logic wr_mark_stb = 1'b0;
  logic [AW-1:0] wr_mark_addr = '0;
  logic rd_en_n = 1'b1, rd_clr_n = 1'b1, rd_set_n = 1'b1;
  logic clr_edge_mode = 1'b0, set_edge_mode = 1'b0;
  logic mark_sel = 1'b1, src_sel = 1'b0;
  logic [AW-1:0] preset_addr = '0, ext_addr = '0;
  logic [AW-1:0] rd_addr;
  logic rd_strobe;

  int errs = 0, checks = 0;
  bit done = 0;

  always #2 rclk = ~rclk;
  always #3.5 wclk = ~wclk;

  rdptr_ctrl #(.AW(AW)) u_dut (
    .rclk(rclk), .rst_n(rst_n), .wclk(wclk), .wrst_n(wrst_n),
    .wr_mark_stb(wr_mark_stb), .wr_mark_addr(wr_mark_addr),
    .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n), .rd_set_n(rd_set_n),
    .clr_edge_mode(clr_edge_mode), .set_edge_mode(set_edge_mode),
    .mark_sel(mark_sel), .src_sel(src_sel),
    .preset_addr(preset_addr), .ext_addr(ext_addr),
    .rd_addr(rd_addr), .rd_strobe(rd_strobe)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge rclk);
  endtask

  task automatic t_reset();
    chk("R1 addr", rd_addr, 0);
    chk("R1 strobe", AW'(rd_strobe), 0);
  endtask

  task automatic t_inc_hold();
    rd_en_n = 0;
    tick(); chk("R2", rd_addr, 1); chk("R9 strobe on", AW'(rd_strobe), 1);
    tick(); chk("R2", rd_addr, 2);
    tick(); chk("R2", rd_addr, 3);
    rd_en_n = 1; rd_clr_n = 0; rd_set_n = 0;
    tick(); chk("R3", rd_addr, 3); chk("R9 strobe off", AW'(rd_strobe), 0);
    tick(); chk("R3", rd_addr, 3);
    rd_clr_n = 1; rd_set_n = 1;
    tick(); chk("R3", rd_addr, 3);
  endtask

  task automatic t_clr_level();
    rd_en_n = 0;
    tick(); chk("R2", rd_addr, 4);
    rd_clr_n = 0;
    tick(); chk("R4", rd_addr, 0);
    tick(); chk("R4 held", rd_addr, 0);
    rd_clr_n = 1;
    tick(); chk("R2", rd_addr, 1);
  endtask

  task automatic t_clr_edge();
    clr_edge_mode = 1;
    tick(); chk("R2", rd_addr, 2);
    rd_clr_n = 0;
    tick(); chk("R5 edge", rd_addr, 0);
    tick(); chk("R5 after", rd_addr, 1);
    tick(); chk("R5 after", rd_addr, 2);
    rd_clr_n = 1;
    tick(); chk("R2", rd_addr, 3);
    clr_edge_mode = 0;
  endtask

  task automatic t_set_sources();
    mark_sel = 1; src_sel = 0; preset_addr = 24'h123456; rd_set_n = 0;
    tick(); chk("R6 preset", rd_addr, 24'h123456);
    tick(); chk("R7 level", rd_addr, 24'h123456);
    src_sel = 1; ext_addr = 24'hABCDEF;
    tick(); chk("R6 ext", rd_addr, 24'hABCDEF);
    rd_set_n = 1;
    tick(); chk("R2", rd_addr, 24'hABCDF0);
  endtask

  task automatic t_set_edge();
    set_edge_mode = 1; ext_addr = 24'h000100;
    tick(); chk("R2", rd_addr, 24'hABCDF1);
    rd_set_n = 0;
    tick(); chk("R7 edge", rd_addr, 24'h000100);
    tick(); chk("R7 after", rd_addr, 24'h000101);
    rd_set_n = 1;
    tick(); chk("R2", rd_addr, 24'h000102);
    set_edge_mode = 0;
  endtask

  task automatic t_priority();
    rd_clr_n = 0; rd_set_n = 0;
    tick(); chk("R8", rd_addr, 0);
    rd_clr_n = 1; rd_set_n = 1;
    tick(); chk("R2", rd_addr, 1);
  endtask

  task automatic do_mark(input logic [AW-1:0] a);
    @(negedge wclk); wr_mark_stb = 1; wr_mark_addr = a;
    @(negedge wclk); wr_mark_stb = 0;
    tick();
  endtask

  task automatic t_mark();
    mark_sel = 0; rd_set_n = 0;
    tick(); chk("R1 mark reset", rd_addr, 0);
    rd_set_n = 1; rd_en_n = 1;
    do_mark(24'h00BEEF);
    repeat (8) tick();
    rd_en_n = 0; rd_set_n = 0;
    tick(); chk("R10 mark", rd_addr, 24'h00BEEF);
    rd_set_n = 1;
    tick(); chk("R2", rd_addr, 24'h00BEF0);
    rd_en_n = 1;
    do_mark(24'h777777);
    repeat (8) tick();
    rd_en_n = 0; rd_set_n = 0;
    tick(); chk("R10 remark", rd_addr, 24'h777777);
    rd_set_n = 1;
  endtask

  task automatic t_wrap();
    mark_sel = 1; src_sel = 1; ext_addr = 24'hFFFFFE; rd_set_n = 0;
    tick(); chk("R6 ext", rd_addr, 24'hFFFFFE);
    rd_set_n = 1;
    tick(); chk("R11", rd_addr, 24'hFFFFFF);
    tick(); chk("R11 wrap", rd_addr, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; wrst_n = 1;
    tick();
    t_reset();
    t_inc_hold();
    t_clr_level();
    t_clr_edge();
    t_set_sources();
    t_set_edge();
    t_priority();
    t_mark();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge rclk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule